// File: doc/BRIEF.md
# Receive DC Offset Calibration Sequencer

This block steers the cancellation of DC offset in a receive baseband chain. A start pulse closes two path-shorting switches, one around the programmable-gain amplifier and one around the digital filter. The sequencer then finds a 6-bit code for the amplifier's offset-correction current DAC by successive approximation. Each trial bit is given a settle interval, after which an external sign comparator decides whether the bit stays.

When the amplifier search ends, the amplifier switch opens and a longer settle wait lets the on-chip filters recover. The sequencer then collects a power-of-two number of residual-offset samples from the filter path. It averages them with a floor shift and stores the negated mean as the value the filter subtracts. The filter switch opens, a one-cycle done pulse is raised and busy drops.

The analog circuitry and the filter datapath are outside the block. It only produces codes and switch controls, and it observes one sign bit and one sample stream.

Top module: `dccal_seq`

## Requirements
- R1: After reset, busy_o, done_o, short_pga_o and short_filt_o are 0, dac_code_o is 6'b100000 and filt_corr_o is 0.
- R2: A start_i pulse taken while idle makes busy_o, short_pga_o and short_filt_o 1 on the following cycle, with dac_code_o reset to mid-scale 6'b100000.
- R3: The DAC code is searched from bit 5 down to bit 0. Each trial bit is set, and at the end of its settle interval cmp_i is sampled: cmp_i=1 (offset above zero) clears the bit, cmp_i=0 keeps it. With a comparator that reports 1 exactly when the code exceeds a target T, the final code equals T for every T from 0 to 63.
- R4: Each bit decision follows BIT_SETTLE wait cycles plus one decision cycle. When filt_valid_i is held high, busy_o stays high for exactly 6*(BIT_SETTLE+1)+STAGE_SETTLE+2^AVG_LOG2 cycles.
- R5: short_pga_o opens right after the last bit decision. short_filt_o stays closed through the STAGE_SETTLE wait and the sample capture, then opens with done. short_pga_o is never 1 while short_filt_o is 0.
- R6: The filter stage takes the first 2^AVG_LOG2 cycles with filt_valid_i=1 after the settle wait, skipping cycles with filt_valid_i=0. It computes the signed sum shifted right arithmetically by AVG_LOG2 (a floor) and stores its two's-complement negation on filt_corr_o, saturating to the most positive value when the mean is the most negative value.
- R7: done_o is high for exactly one cycle, on the cycle busy_o first reads 0. dac_code_o and filt_corr_o then hold until the next start.
- R8: A start_i pulse while busy_o is 1, including the last busy cycle, has no effect on the running sequence or its length, and starts no new one.
- R9: A start_i pulse in the cycle done_o is high begins a new calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Calibration request pulse |
| cmp_i | input | 1 | Offset sign: 1 when the amplifier output offset is above zero |
| filt_valid_i | input | 1 | Qualifies filt_sample_i |
| filt_sample_i | input | SAMPLE_W (12) | Signed residual offset sample from the filter path |
| dac_code_o | output | CODE_W (6) | Amplifier offset-correction DAC code |
| filt_corr_o | output | SAMPLE_W (12) | Signed value the filter subtracts |
| short_pga_o | output | 1 | Closes the switch shorting the amplifier input |
| short_filt_o | output | 1 | Closes the switch shorting the filter input |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The end of one calibration and the arrival of the next request can fall in the same cycle. This happens in two ways, and the outcome depends on which side of the done edge the request lands. The bench counts busy cycles from a known start and raises start_i during the final capture cycle. The design must finish on schedule with done high and busy staying low afterwards. The bench also raises start_i exactly in the cycle done is seen, and expects busy on the next cycle followed by a second correct result from the scoreboard queue.

// File: rtl/dccal_pkg.sv
package dccal_pkg;

  typedef enum logic [2:0] {
    CAL_IDLE,
    CAL_BIT_WAIT,
    CAL_BIT_DECIDE,
    CAL_STAGE_WAIT,
    CAL_CAPTURE
  } cal_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dccal_timer.sv
module dccal_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != '0) |=> !expired_o); // R4

endmodule

// File: rtl/dccal_sar.sv
module dccal_sar #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              decide_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] code_o,
  output logic              last_o
);

  localparam int unsigned IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(CODE_W - 1);

  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  idx_q;

  // One successive-approximation step: drop the trial bit when the offset is
  // positive, then place the next lower trial bit.
  function automatic logic [CODE_W-1:0] sar_step(input logic [CODE_W-1:0] code,
                                                 input logic [IDX_W-1:0]  idx,
                                                 input logic              above);
    logic [CODE_W-1:0] r;
    r = code;
    if (above) r[idx] = 1'b0;
    if (idx != '0) r[idx - 1'b1] = 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID_CODE;
      idx_q  <= TOP_IDX;
    end else if (init_i) begin
      code_q <= MID_CODE;
      idx_q  <= TOP_IDX;
    end else if (decide_i) begin
      code_q <= sar_step(code_q, idx_q, cmp_i);
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end

  assign code_o = code_q;
  assign last_o = (idx_q == '0);

  AST_SAR_MIDSCALE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (code_o == MID_CODE)); // R2

  AST_SAR_UPPER_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_i && !init_i) |=>
      ((code_o >> ($past(idx_q) + 1)) == ($past(code_o) >> ($past(idx_q) + 1)))); // R3

  AST_SAR_CODE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!decide_i && !init_i) |=> $stable(code_o)); // R7

endmodule

// File: rtl/dccal_avg.sv
module dccal_avg #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned AVG_LOG2 = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       en_i,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       last_o,
  output logic signed [SAMPLE_W-1:0] corr_o
);

  localparam int unsigned NUM   = 1 << AVG_LOG2;
  localparam int unsigned ACC_W = SAMPLE_W + AVG_LOG2;
  localparam int unsigned CNT_W = AVG_LOG2 + 1;
  localparam logic signed [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [SAMPLE_W-1:0] S_MAX = ~S_MIN;

  logic signed [ACC_W-1:0]    acc_q;
  logic signed [ACC_W-1:0]    sample_ext;
  logic signed [ACC_W-1:0]    acc_sum;
  logic [CNT_W-1:0]           cnt_q;
  logic signed [SAMPLE_W-1:0] corr_q;
  logic                       take;

  function automatic logic signed [SAMPLE_W-1:0] floor_mean(input logic signed [ACC_W-1:0] total);
    logic signed [ACC_W-1:0] sh;
    sh = total >>> AVG_LOG2;
    return sh[SAMPLE_W-1:0];
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] neg_sat(input logic signed [SAMPLE_W-1:0] v);
    return (v == S_MIN) ? S_MAX : -v;
  endfunction

  assign sample_ext = sample_i;
  assign acc_sum    = acc_q + sample_ext;
  assign take       = en_i && valid_i;
  assign last_o     = take && (cnt_q == CNT_W'(NUM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      corr_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (last_o) begin
      corr_q <= neg_sat(floor_mean(acc_sum));
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (take) begin
      acc_q <= acc_sum;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign corr_o = corr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(NUM)); // R6

  AST_CORR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !last_o |=> $stable(corr_o)); // R7

  AST_SKIP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !valid_i && !clear_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/dccal_seq.sv
module dccal_seq #(
  parameter int unsigned CODE_W       = 6,
  parameter int unsigned SAMPLE_W     = 12,
  parameter int unsigned BIT_SETTLE   = 4,
  parameter int unsigned STAGE_SETTLE = 10,
  parameter int unsigned AVG_LOG2     = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       cmp_i,
  input  logic                       filt_valid_i,
  input  logic signed [SAMPLE_W-1:0] filt_sample_i,
  output logic [CODE_W-1:0]          dac_code_o,
  output logic signed [SAMPLE_W-1:0] filt_corr_o,
  output logic                       short_pga_o,
  output logic                       short_filt_o,
  output logic                       busy_o,
  output logic                       done_o
);
  import dccal_pkg::*;

  localparam int unsigned WAIT_MAX = max_u(BIT_SETTLE, STAGE_SETTLE);
  localparam int unsigned TMR_W    = $clog2(WAIT_MAX + 1);
  localparam logic [TMR_W-1:0] BIT_RELOAD   = TMR_W'(BIT_SETTLE - 1);
  localparam logic [TMR_W-1:0] STAGE_RELOAD = TMR_W'(STAGE_SETTLE - 1);

  cal_state_e state_q, state_d;

  logic busy_q, done_q, short_pga_q, short_filt_q;

  // Named internal events
  logic ev_start;       // accepted start request
  logic ev_bit_decide;  // comparator sampled for the current trial bit
  logic ev_next_bit;    // decision made, more bits remain
  logic ev_sar_end;     // last bit decided, amplifier switch opens
  logic ev_settle_end;  // inter-stage settle wait finished
  logic ev_cap_end;     // final filter sample taken

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             sar_last;
  logic             cap_en;

  assign ev_start      = start_i && (state_q == CAL_IDLE);
  assign ev_bit_decide = (state_q == CAL_BIT_DECIDE);
  assign ev_next_bit   = ev_bit_decide && !sar_last;
  assign ev_sar_end    = ev_bit_decide && sar_last;
  assign ev_settle_end = (state_q == CAL_STAGE_WAIT) && tmr_expired;
  assign cap_en        = (state_q == CAL_CAPTURE);

  assign tmr_load = ev_start || ev_next_bit || ev_sar_end;
  assign tmr_val  = ev_sar_end ? STAGE_RELOAD : BIT_RELOAD;

  dccal_timer #(.CNT_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  dccal_sar #(.CODE_W(CODE_W)) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (ev_start),
    .decide_i (ev_bit_decide),
    .cmp_i    (cmp_i),
    .code_o   (dac_code_o),
    .last_o   (sar_last)
  );

  dccal_avg #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (ev_settle_end),
    .en_i     (cap_en),
    .valid_i  (filt_valid_i),
    .sample_i (filt_sample_i),
    .last_o   (ev_cap_end),
    .corr_o   (filt_corr_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CAL_IDLE:       if (ev_start) state_d = CAL_BIT_WAIT;
      CAL_BIT_WAIT:   if (tmr_expired) state_d = CAL_BIT_DECIDE;
      CAL_BIT_DECIDE: state_d = sar_last ? CAL_STAGE_WAIT : CAL_BIT_WAIT;
      CAL_STAGE_WAIT: if (tmr_expired) state_d = CAL_CAPTURE;
      CAL_CAPTURE:    if (ev_cap_end) state_d = CAL_IDLE;
      default:        state_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= CAL_IDLE;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      short_pga_q  <= 1'b0;
      short_filt_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= ev_cap_end;
      if (ev_start) begin
        busy_q       <= 1'b1;
        short_pga_q  <= 1'b1;
        short_filt_q <= 1'b1;
      end else begin
        if (ev_sar_end) short_pga_q <= 1'b0;
        if (ev_cap_end) begin
          short_filt_q <= 1'b0;
          busy_q       <= 1'b0;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign short_pga_o  = short_pga_q;
  assign short_filt_o = short_filt_q;

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (busy_o && short_pga_o && short_filt_o)); // R2

  AST_SWITCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    short_pga_o |-> short_filt_o); // R5

  AST_PGA_OPENS_AT_SAR_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(short_pga_o) |-> (state_q == CAL_STAGE_WAIT)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !short_filt_o)); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !ev_cap_end) |=> busy_o); // R8

  AST_LATE_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cap_end && start_i) |=> !busy_o); // R8

  AST_START_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> busy_o); // R9

endmodule

// File: tb/dccal_seq_bench.sv
`timescale 1ns/1ps
module dccal_seq_bench;

  localparam int BS  = 4;
  localparam int SS  = 10;
  localparam int NS  = 8;
  localparam int LEN = 6 * (BS + 1) + SS + NS;

  typedef struct {
    int code;
    int corr;
    bit chk_len;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp;
  logic filt_valid = 1'b1;
  logic signed [11:0] filt_sample = '0;
  logic [5:0] dac_code;
  logic signed [11:0] filt_corr;
  logic short_pga, short_filt, busy, done;

  int target = 0;
  int base_v = 0;
  bit pat_v  = 1'b0;
  bit gaps_v = 1'b0;
  int tests  = 0;
  int fails  = 0;
  bit finished = 1'b0;
  exp_t q[$];
  int delta [8] = '{3, -1, 2, -5, 4, 0, -6, 2};

  always #2.5 clk = ~clk;

  dccal_seq #(
    .CODE_W(6), .SAMPLE_W(12), .BIT_SETTLE(BS), .STAGE_SETTLE(SS), .AVG_LOG2(3)
  ) u_dccal_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .cmp_i         (cmp),
    .filt_valid_i  (filt_valid),
    .filt_sample_i (filt_sample),
    .dac_code_o    (dac_code),
    .filt_corr_o   (filt_corr),
    .short_pga_o   (short_pga),
    .short_filt_o  (short_filt),
    .busy_o        (busy),
    .done_o        (done)
  );

  // Comparator model: offset positive when the code overshoots the target
  assign cmp = (int'(dac_code) > target);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_corr(input int base, input bit pat);
    int s, a, c;
    s = NS * base + (pat ? -1 : 0);
    a = (s >= 0) ? s / NS : -((-s + NS - 1) / NS);
    c = -a;
    if (c > 2047) c = 2047;
    return c;
  endfunction

  // Sample source: periodic pattern so any NS consecutive valid samples share a sum
  initial begin
    int idx = 0;
    int cyc = 0;
    forever begin
      @(negedge clk);
      if (filt_valid) idx = (idx + 1) % 8;
      cyc++;
      filt_valid  = gaps_v ? ((cyc % 3) != 0) : 1'b1;
      filt_sample = 12'(base_v + (pat_v ? delta[idx] : 0));
    end
  end

  // Monitor: pops expected results at each done pulse
  initial begin
    int  busy_len = 0;
    int  rel_len  = 0;
    bit  prev_done = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (short_pga && !short_filt)
          chk(1'b0, "R5", "amplifier switch closed with filter switch open", 1, 0);
        if (done) begin
          if (prev_done) chk(1'b0, "R7", "done longer than one cycle", 2, 1);
          if (q.size() == 0) begin
            chk(1'b0, "R7", "unexpected done", 1, 0);
          end else begin
            e = q.pop_front();
            chk(int'(dac_code) == e.code, "R3", "final DAC code", int'(dac_code), e.code);
            chk(int'(filt_corr) == e.corr, "R6", "filter correction", int'(filt_corr), e.corr);
            chk(!short_pga && !short_filt && !busy, "R5", "switches open and idle at done",
                {short_pga, short_filt, busy}, 0);
            if (e.chk_len) begin
              chk(busy_len == LEN, "R4", "busy length", busy_len, LEN);
              chk(rel_len == SS + NS, "R5", "cycles with only filter switch closed",
                  rel_len, SS + NS);
            end
          end
          busy_len = 0;
          rel_len  = 0;
        end
        if (busy) busy_len++;
        if (busy && !short_pga && short_filt) rel_len++;
        prev_done = done;
      end
    end
  end

  // Driver: called at a negedge; pushes the expected result then pulses start
  task automatic launch(input int tgt, input int base, input bit pat, input bit gaps,
                        input bit chk_len);
    exp_t e;
    target = tgt;
    base_v = base;
    pat_v  = pat;
    gaps_v = gaps;
    e.code = tgt;
    e.corr = exp_corr(base, pat);
    e.chk_len = chk_len;
    q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && short_pga && short_filt, "R2", "armed after start",
        {busy, short_pga, short_filt}, 7);
    chk(dac_code == 6'b100000, "R2", "mid-scale code after start", int'(dac_code), 32);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_hold(input int tgt, input int base, input bit pat);
    @(negedge clk);
    chk(int'(dac_code) == tgt && int'(filt_corr) == exp_corr(base, pat), "R7",
        "outputs hold after done", int'(dac_code), tgt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!short_pga && !short_filt, "R1", "switches after reset", {short_pga, short_filt}, 0);
    chk(dac_code == 6'b100000, "R1", "code after reset", int'(dac_code), 32);
    chk(filt_corr == 0, "R1", "correction after reset", int'(filt_corr), 0);

    // R3/R4/R6: code boundary 0, positive residual
    launch(0, 5, 1'b1, 1'b0, 1'b1);
    wait_done();
    check_hold(0, 5, 1'b1);

    // R3/R6: code boundary 63, negative residual exercises floor
    launch(63, -5, 1'b1, 1'b0, 1'b1);
    wait_done();
    check_hold(63, -5, 1'b1);

    // R6: gapped valid samples
    launch(37, 100, 1'b1, 1'b1, 1'b0);
    wait_done();
    check_hold(37, 100, 1'b1);

    // R6: saturating negation of the most negative mean
    launch(32, -2048, 1'b0, 1'b0, 1'b1);
    wait_done();
    check_hold(32, -2048, 1'b0);

    // R8: start in the middle of a run is ignored (length checked by monitor)
    launch(21, 0, 1'b1, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    @(negedge clk);

    // R8: start in the final busy cycle is ignored
    launch(10, 7, 1'b1, 1'b0, 1'b1);
    repeat (LEN - 1) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy, "R8", "done on schedule despite late start", {done, busy}, 2);
    @(negedge clk);
    chk(!busy, "R8", "no new run from late start", busy, 0);

    // R9: start in the done cycle launches a new run
    launch(50, -20, 1'b1, 1'b0, 1'b1);
    wait_done();
    launch(13, 33, 1'b1, 1'b0, 1'b1);
    chk(busy, "R9", "run begun from done cycle", busy, 1);
    wait_done();
    check_hold(13, 33, 1'b1);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R7", "all expected results produced", q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule